// File: doc/BRIEF.md
# Serial Command-Register Port

This block is a serial slave that gives a host read and write access to a small bank of per-channel command registers. The host frames each transaction with an active-low chip select and toggles a serial clock. Every frame starts with an 8-bit header. The header carries a direction bit, a 5-bit register address sent least significant bit first, a reserved bit that must be zero and a spare bit that the block ignores. An 8-bit data phase follows the header. In that phase the host either shifts a word in or receives the addressed register shifted out, least significant bit first in both cases.

Each channel owns two adjacent addresses. The lower one is a 5-bit configuration register that the host can read and write. The upper one is a read-only status word whose bit 0 mirrors the channel's status input. All logic runs in the serial-clock domain. Input bits are captured on rising edges and output bits are launched on falling edges. The data output comes with an output-enable, so the pad can be tri-stated whenever the block is not returning read data.

Top module: `sctl_port`

## Requirements
- R1: Header bit 0 is the direction bit, where 1 means read and 0 means write. Header bits 1 to 5 carry address bits 0 to 4, least significant bit first. Every header bit is sampled on a rising edge of `sclk` while `cs_n` is low.
- R2: A complete write to a configuration address stores bits 4:0 of the data word and drops bits 7:5. Channel c's configuration address is c*8+6, so the addresses are 0x06, 0x0E and 0x16. A read of that address returns the stored value with bits 7:5 at zero. `cfg_o[5c+4:5c]` shows the same value. A frame commits at most once.
- R3: A read of a status address returns `stat_i[c]` in bit 0 and zero in bits 7:1. Channel c's status address is c*8+7, so the addresses are 0x07, 0x0F and 0x17. The status input is sampled at the eighth header edge.
- R4: `sdo_oe` stays low through the header. In a read frame it rises on the falling edge that follows the eighth header rising edge. `sdo` then presents data bit 0 first and advances one bit per falling edge. `sdo_oe` drops on the falling edge after the eighth data bit.
- R5: If header bit 6 is 1, a write leaves every register unchanged and a read returns all zeros.
- R6: Header bit 7 has no effect on either reads or writes.
- R7: A write to a status address or to an unmapped address leaves every register unchanged. A read of an unmapped address returns zero.
- R8: Raising `cs_n` at any point ends the frame. `sdo_oe` drops at once, the bit position restarts at the next frame, and a write that has not received all 8 data bits is discarded.
- R9: Holding `rst` high across a rising `sclk` edge clears all configuration registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs captured on rising edges, data launched on falling edges |
| rst | input | 1 | Synchronous active-high reset in the `sclk` domain |
| cs_n | input | 1 | Active-low frame select; high aborts and idles the port |
| sdi | input | 1 | Serial data in: header then write data, LSB first |
| stat_i | input | NCH | Per-channel status flags, reported in bit 0 of the status word |
| sdo | output | 1 | Serial read data, LSB first |
| sdo_oe | output | 1 | Output enable for `sdo`; low means the pad is high-impedance |
| cfg_o | output | NCH*CFG_W | Configuration registers, channel c in bits [c*CFG_W +: CFG_W] |

## Verification
If the bit counter is wrong by one position, two things go wrong in the very next frame. Read data comes back shifted by one bit, and the output-enable rises a cycle early or late. This shows up within one 16-clock frame. If the address decode or the commit strobe is wrong, the fault stays hidden until the affected register is read back or appears on `cfg_o`. For that reason, every write scenario is followed at once by reads of its own channel and of the neighbouring channels. A stuck output-enable is visible at the port immediately, because the bench checks `sdo_oe` at every header bit and right after every abort.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  // Position of the current rising edge inside a frame
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_END  = 2'd2
  } sctl_phase_e;

  // Header bit positions relative to the direction bit
  localparam int HDR_DIR_POS = 0;
  localparam int HDR_ADDR_POS = 1;

endpackage

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sdi,
  output sctl_phase_e       phase,
  output logic              is_rd,
  output logic              rsv_bit,
  output logic [ADDR_W-1:0] addr,
  output logic              ld_stb,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data
);

  localparam int HDR_W     = ADDR_W + 3;
  localparam int FRAME_LEN = HDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_HDR_END  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST_HDR = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_DONE     = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] dsh;

  // Bit counter; chip select high clears it without a clock
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      cnt <= '0;
    end else if (rst) begin
      cnt <= '0;
    end else if (cnt != CNT_DONE) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Header and write-data capture
  always_ff @(posedge sclk) begin
    if (rst) begin
      hdr <= '0;
      dsh <= '0;
    end else if (!cs_n) begin
      if (cnt < CNT_HDR_END) begin
        hdr[cnt] <= sdi;
      end else if (cnt != CNT_DONE) begin
        dsh <= {sdi, dsh[DATA_W-1:1]};
      end
    end
  end

  always_comb begin
    if (cnt < CNT_HDR_END) begin
      phase = PH_HDR;
    end else if (cnt != CNT_DONE) begin
      phase = PH_DATA;
    end else begin
      phase = PH_END;
    end
  end

  assign is_rd   = hdr[HDR_DIR_POS];
  assign addr    = hdr[HDR_ADDR_POS +: ADDR_W];
  assign rsv_bit = hdr[HDR_ADDR_POS + ADDR_W];
  assign ld_stb  = !cs_n && !rst && (cnt == CNT_LAST_HDR);
  assign wr_stb  = !cs_n && !rst && (cnt == CNT_LAST) && !hdr[HDR_DIR_POS];
  assign wr_data = {sdi, dsh[DATA_W-1:1]};

  // R2: a commit strobe never lasts more than one edge
  a_r2_single_commit: assert property (@(posedge sclk) disable iff (rst || cs_n)
    wr_stb |=> !wr_stb);

  // R8: counter never runs past the end of the frame
  a_r8_cnt_bounded: assert property (@(posedge sclk) disable iff (rst)
    cnt <= CNT_DONE);

endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank #(
  parameter int NCH      = 3,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int CFG_W    = 5,
  parameter int STRIDE   = 8,
  parameter int CFG_OFS  = 6,
  parameter int STAT_OFS = 7
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              rsv_bit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    stat_i,
  output logic [DATA_W-1:0] rd_word,
  output logic [NCH*CFG_W-1:0] cfg_o
);

  logic [NCH-1:0]             hit_cfg;
  logic [NCH-1:0]             hit_stat;
  logic [NCH-1:0][DATA_W-1:0] part;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(c * STRIDE + CFG_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(c * STRIDE + STAT_OFS);

    logic [CFG_W-1:0] q;

    assign hit_cfg[c]  = (addr == A_CFG);
    assign hit_stat[c] = (addr == A_STAT);

    always_ff @(posedge sclk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_stb && !rsv_bit && hit_cfg[c]) begin
        q <= wr_data[CFG_W-1:0];
      end
    end

    assign cfg_o[c*CFG_W +: CFG_W] = q;

    always_comb begin
      part[c] = '0;
      if (hit_cfg[c]) begin
        part[c][CFG_W-1:0] = q;
      end else if (hit_stat[c]) begin
        part[c][0] = stat_i[c];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (!rsv_bit) begin
      for (int c = 0; c < NCH; c++) begin
        rd_word = rd_word | part[c];
      end
    end
  end

  // R5: reserved bit set blocks every register update
  a_r5_rsv_blocks_write: assert property (@(posedge sclk) disable iff (rst)
    (wr_stb && rsv_bit) |=> $stable(cfg_o));

  // R7: writes that miss every configuration address change nothing
  a_r7_miss_holds: assert property (@(posedge sclk) disable iff (rst)
    (wr_stb && !(|hit_cfg)) |=> $stable(cfg_o));

  // R2: registers change only on a commit
  a_r2_hold_idle: assert property (@(posedge sclk) disable iff (rst)
    !wr_stb |=> $stable(cfg_o));

  // R3: status reads carry at most bit 0
  a_r3_status_d0_only: assert property (@(posedge sclk) disable iff (rst)
    (|hit_stat) |-> ($countones(rd_word[DATA_W-1:1]) == 0));

endmodule

// File: rtl/sctl_shift_out.sv
module sctl_shift_out
  import sctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              cs_n,
  input  sctl_phase_e       phase,
  input  logic              is_rd,
  input  logic              ld_stb,
  input  logic [DATA_W-1:0] rd_word,
  output logic              sdo,
  output logic              sdo_oe
);

  logic [DATA_W-1:0] sh;
  logic              drive;

  assign drive = is_rd && (phase == PH_DATA);

  // Load at the last header edge, advance on each data edge
  always_ff @(posedge sclk) begin
    if (rst) begin
      sh <= '0;
    end else if (ld_stb) begin
      sh <= rd_word;
    end else if (!cs_n && phase == PH_DATA) begin
      sh <= {1'b0, sh[DATA_W-1:1]};
    end
  end

  // Launch on falling edges; chip select high releases the pad at once
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo_oe <= drive;
      sdo    <= drive ? sh[0] : 1'b0;
    end
  end

  // R4: no drive during the header
  a_r4_quiet_header: assert property (@(posedge sclk) disable iff (rst || cs_n)
    (phase == PH_HDR) |-> !sdo_oe);

  // R8: an idle select never drives
  a_r8_idle_released: assert property (@(posedge sclk) disable iff (rst)
    cs_n |-> !sdo_oe);

  // R4: a write frame never drives
  a_r4_write_quiet: assert property (@(posedge sclk) disable iff (rst || cs_n)
    (phase != PH_HDR && !is_rd) |-> !sdo_oe);

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int CFG_W    = 5,
  parameter int STRIDE   = 8,
  parameter int CFG_OFS  = 6,
  parameter int STAT_OFS = 7
) (
  input  logic                 sclk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 sdi,
  input  logic [NCH-1:0]       stat_i,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic [NCH*CFG_W-1:0] cfg_o
);

  sctl_phase_e       phase;
  logic              is_rd;
  logic              rsv_bit;
  logic [ADDR_W-1:0] addr;
  logic              ld_stb;
  logic              wr_stb;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;

  sctl_frame #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) frame_i (
    .sclk    (sclk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sdi     (sdi),
    .phase   (phase),
    .is_rd   (is_rd),
    .rsv_bit (rsv_bit),
    .addr    (addr),
    .ld_stb  (ld_stb),
    .wr_stb  (wr_stb),
    .wr_data (wr_data)
  );

  sctl_regbank #(
    .NCH      (NCH),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CFG_W    (CFG_W),
    .STRIDE   (STRIDE),
    .CFG_OFS  (CFG_OFS),
    .STAT_OFS (STAT_OFS)
  ) bank_i (
    .sclk    (sclk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .rsv_bit (rsv_bit),
    .addr    (addr),
    .wr_data (wr_data),
    .stat_i  (stat_i),
    .rd_word (rd_word),
    .cfg_o   (cfg_o)
  );

  sctl_shift_out #(
    .DATA_W (DATA_W)
  ) out_i (
    .sclk    (sclk),
    .rst     (rst),
    .cs_n    (cs_n),
    .phase   (phase),
    .is_rd   (is_rd),
    .ld_stb  (ld_stb),
    .rd_word (rd_word),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

  // R9: reset leaves every configuration register cleared
  a_r9_reset_clears: assert property (@(posedge sclk)
    rst |=> (cfg_o == '0));

endmodule

// File: tb/sctl_port_tb_top.sv
module sctl_port_tb_top;

  logic       sclk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sdi = 1'b0;
  logic [2:0] stat_i = '0;
  logic       sdo;
  logic       sdo_oe;
  logic [14:0] cfg_o;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 sclk = ~sclk;

  sctl_port dut_i (
    .sclk   (sclk),
    .rst    (rst),
    .cs_n   (cs_n),
    .sdi    (sdi),
    .stat_i (stat_i),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .cfg_o  (cfg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Drives nbits of a frame, then raises cs_n; counts enable timing errors
  task automatic xfer(input logic rd, input logic [4:0] a, input logic a5, input logic a6,
                      input logic [7:0] wd, input int nbits,
                      output logic [7:0] q, output int oe_err);
    logic [15:0] bits;
    bits = {wd, a6, a5, a, rd};
    q = '0;
    oe_err = 0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge sclk);
      #1 cs_n = 1'b0;
      sdi = bits[k];
      #5;
      if (k < 8) begin
        if (sdo_oe !== 1'b0) oe_err++;
      end else begin
        if (sdo_oe !== rd) oe_err++;
        q[k-8] = sdo;
      end
    end
    if (nbits == 16) begin
      @(negedge sclk);
      #6;
      if (sdo_oe !== 1'b0) oe_err++;
    end
    @(negedge sclk);
    #1 cs_n = 1'b1;
    sdi = 1'b0;
    #2;
    if (sdo_oe !== 1'b0) oe_err++;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] q;
    int e;
    xfer(1'b0, a, 1'b0, 1'b0, d, 16, q, e);
    chk("R4 write frame keeps pad released", e, 0);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] q;
    int e;
    xfer(1'b1, a, 1'b0, 1'b0, 8'h00, 16, q, e);
    chk(req, q, exp);
    chk("R4 read enable timing", e, 0);
  endtask

  task automatic t_reset;
    chk("R9 cfg clear after reset", cfg_o, 0);
    chk("R4 pad released at idle", sdo_oe, 0);
    rd_chk("R9 read after reset", 5'h06, 8'h00);
  endtask

  task automatic t_cfg_rw;
    wr(5'h06, 8'hFF);
    chk("R2 upper bits dropped on cfg_o", cfg_o[4:0], 5'h1F);
    rd_chk("R2 R1 readback ch0", 5'h06, 8'h1F);
    wr(5'h0E, 8'h15);
    wr(5'h16, 8'hEA);
    chk("R2 ch1 on cfg_o", cfg_o[9:5], 5'h15);
    chk("R2 ch2 on cfg_o", cfg_o[14:10], 5'h0A);
    rd_chk("R2 readback ch1", 5'h0E, 8'h15);
    rd_chk("R2 readback ch2", 5'h16, 8'h0A);
    rd_chk("R2 ch0 untouched by others", 5'h06, 8'h1F);
  endtask

  task automatic t_status;
    stat_i = 3'b101;
    rd_chk("R3 status ch0", 5'h07, 8'h01);
    rd_chk("R3 status ch1", 5'h0F, 8'h00);
    rd_chk("R3 status ch2", 5'h17, 8'h01);
    stat_i = 3'b010;
    rd_chk("R3 status ch1 set", 5'h0F, 8'h01);
  endtask

  task automatic t_rsv;
    logic [7:0] q;
    int e;
    xfer(1'b0, 5'h06, 1'b1, 1'b0, 8'h00, 16, q, e);
    chk("R5 reserved write ignored", cfg_o[4:0], 5'h1F);
    xfer(1'b1, 5'h06, 1'b1, 1'b0, 8'h00, 16, q, e);
    chk("R5 reserved read is zero", q, 8'h00);
    chk("R5 reserved read enable", e, 0);
  endtask

  task automatic t_spare;
    logic [7:0] q;
    int e;
    xfer(1'b0, 5'h0E, 1'b0, 1'b1, 8'h03, 16, q, e);
    chk("R6 spare bit write applied", cfg_o[9:5], 5'h03);
    xfer(1'b1, 5'h0E, 1'b0, 1'b1, 8'h00, 16, q, e);
    chk("R6 spare bit read", q, 8'h03);
  endtask

  task automatic t_unmapped;
    wr(5'h07, 8'h00);
    wr(5'h05, 8'h00);
    wr(5'h1E, 8'h00);
    chk("R7 cfg unchanged after stray writes", cfg_o, {5'h0A, 5'h03, 5'h1F});
    rd_chk("R7 unmapped read 0x1E", 5'h1E, 8'h00);
    rd_chk("R7 unmapped read 0x00", 5'h00, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] q;
    int e;
    xfer(1'b0, 5'h16, 1'b0, 1'b0, 8'h1F, 15, q, e);
    chk("R8 partial write dropped", cfg_o[14:10], 5'h0A);
    xfer(1'b1, 5'h06, 1'b0, 1'b0, 8'h00, 12, q, e);
    chk("R8 abort releases pad", e, 0);
    xfer(1'b1, 5'h06, 1'b0, 1'b0, 8'h00, 4, q, e);
    rd_chk("R8 frame after abort", 5'h06, 8'h1F);
  endtask

  task automatic t_rst_again;
    @(negedge sclk);
    #1 rst = 1'b1;
    @(negedge sclk);
    @(negedge sclk);
    #1 rst = 1'b0;
    #2;
    chk("R9 reset clears loaded cfg", cfg_o, 0);
    rd_chk("R9 read ch1 after reset", 5'h0E, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge sclk);
    #1 rst = 1'b0;
    t_reset();
    t_cfg_rw();
    t_status();
    t_rsv();
    t_spare();
    t_unmapped();
    t_abort();
    t_rst_again();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule